// File: doc/BRIEF.md
# Polyphase Decimating Four-Tap Wavelet Analysis Filter

This block is a one-dimensional analysis stage for a four-tap wavelet filter bank. It accepts one signed sample per clock and produces one low-pass or high-pass coefficient for every two accepted samples. The stream is split by sample parity. Two constant-coefficient shift-add processing elements each apply one tap of an even/odd tap pair on every accepted sample. A single partial-sum register carries the two older taps from one output slot to the next, so no four-deep delay line is needed.

A line is `LINE_LEN` samples long. It starts on a sample flagged as start of line, or after the previous line's last sample. The band select and the border mode are taken from the first sample of each line and held until that line ends. The border mode has two settings. With the zero-border setting, samples before index 0 count as zero. With the periodic setting, the block keeps the partial result of samples 0 and 1 aside. It then completes that output with the line's last two samples, so the line wraps around. In both modes a line yields exactly `LINE_LEN/2` outputs.

Top module: `poly_decim4`

## Requirements
- R1: In the cycle after a synchronous reset with `rst_n` low, `out_valid` is 0 and `out_data` is 0. The next accepted sample counts as index 0 of a line.
- R2: An accepted sample with an even index never produces an output. An accepted odd-index sample produces an output in the following cycle, except for the case in R6.
- R3: For odd index 2k+1, the output is c0·x(2k+1) + c1·x(2k) + c2·x(2k−1) + c3·x(2k−2) at full precision. The coefficients are integers scaled by 2^-11. For low-pass, c0..c3 are −265, 459, 1713, 989. For high-pass, c0..c3 are −989, 1713, −459, −265.
- R4: With the zero border, the first output of a line is c0·x(1) + c1·x(0). The partial sum is cleared when the line starts.
- R5: `hp_sel` (1 = high-pass) and `wrap_en` are sampled only with a line's index-0 sample. Changes on later samples of that line have no effect.
- R6: With the periodic border (`wrap_en` = 1), no output follows sample 1. One cycle after the last sample, the block emits c0·x(1) + c1·x(0) + c2·x(N−1) + c3·x(N−2), where N is `LINE_LEN`. A line therefore gives exactly N/2 outputs.
- R7: Cycles with `in_valid` low are ignored, whatever the other inputs are. They do not advance the index and do not produce an output, except for a pending wrap output.
- R8: A valid sample with `in_sol` high restarts the line at index 0 and clears the partial sum, even in the middle of a line.
- R9: A wrap output can fall in the same cycle as the next line's index-0 sample. The wrap output is correct and the next line is processed unaffected.
- R10: After index N−1 the index returns to 0, so the next valid sample starts a new line without `in_sol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | IN_W | Signed input sample |
| in_valid | input | 1 | Sample qualifier |
| in_sol | input | 1 | Marks the index-0 sample of a line |
| hp_sel | input | 1 | Band select, 1 = high-pass, sampled at line start |
| wrap_en | input | 1 | Periodic border enable, sampled at line start |
| out_data | output | IN_W+14 | Signed filter output, scaled by 2^-11 |
| out_valid | output | 1 | Output qualifier |

## Verification
The delicate cycle is the end of a periodic line followed directly by the next line. In that cycle the deferred wrap output reads the partial-sum register, while the new line's index-0 sample clears that register and captures a fresh band and mode. The bench streams several periodic lines back to back with no gap. It checks the value of the wrap output that appears in the same cycle as the next line's first sample. It then checks that the next line's first output carries no residue of the previous tail. The same lines are repeated with idle cycles in between, and with band and mode toggled on non-zero indices.

// File: rtl/poly_decim4_pkg.sv
// Shared types and quantized filter coefficients for the polyphase filter.
// Assumes coefficients are integers scaled by 2^-COEF_FRAC.
package poly_decim4_pkg;

    localparam int COEF_W    = 12;
    localparam int COEF_FRAC = 11;

    typedef enum logic {
        BAND_LO = 1'b0,
        BAND_HI = 1'b1
    } band_e;

    // Tap t (0..3) of the chosen band, as a scaled integer.
    function automatic int tap_coef(band_e band, int t);
        int c;
        if (band == BAND_LO) begin
            case (t)
                0:       c = -265;
                1:       c = 459;
                2:       c = 1713;
                default: c = 989;
            endcase
        end else begin
            case (t)
                0:       c = -989;
                1:       c = 1713;
                2:       c = -459;
                default: c = -265;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/poly_decim4_seq.sv
// Line sequencer: tracks the sample index within a line.
// Assumes LINE_LEN is even and at least 2. A start marker forces index 0.
module poly_decim4_seq #(
    parameter int LINE_LEN = 8,
    localparam int IDX_W   = (LINE_LEN > 2) ? $clog2(LINE_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    output logic [IDX_W-1:0] idx,
    output logic             is_first,
    output logic             is_odd,
    output logic             is_last
);

    logic [IDX_W-1:0] cnt_q;

    // Effective index of the sample now on the input.
    always_comb begin
        idx      = in_sol ? '0 : cnt_q;
        is_first = (idx == '0);
        is_odd   = idx[0];
        is_last  = (idx == IDX_W'(LINE_LEN - 1));
    end

    // Advance the index on each accepted sample, wrapping at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_valid)
            cnt_q <= is_last ? '0 : idx + 1'b1;
    end

    p_index_wraps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_last) |=> (cnt_q == '0));

    p_gap_holds_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q));

endmodule

// File: rtl/poly_decim4_pe.sv
// Processing element: multiplies a sample by one of two hard-wired taps,
// chosen by sample parity, for the selected band. Each constant product is
// a sum of shifted copies of the sample, so no general multiplier is built.
module poly_decim4_pe
    import poly_decim4_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int TAP_EVEN = 1,
    parameter int TAP_ODD  = 0,
    localparam int PW      = IN_W + COEF_W
) (
    input  logic signed [IN_W-1:0] x,
    input  logic                   odd,
    input  band_e                  band,
    output logic signed [PW-1:0]   prod
);

    // Shift-add product of v with the constant c.
    function automatic logic signed [PW-1:0] cmul(input logic signed [IN_W-1:0] v, input int c);
        logic signed [PW-1:0] s;
        int mag;
        s   = '0;
        mag = (c < 0) ? -c : c;
        for (int b = 0; b < COEF_W; b++)
            if (mag[b]) s = s + (PW'(v) <<< b);
        return (c < 0) ? -s : s;
    endfunction

    logic signed [PW-1:0] cand [2][2];

    for (genvar b = 0; b < 2; b++) begin : g_band
        for (genvar p = 0; p < 2; p++) begin : g_phase
            localparam int C = tap_coef(band_e'(b), (p == 1) ? TAP_ODD : TAP_EVEN);
            // Constant product for this band and parity.
            assign cand[b][p] = cmul(x, C);
        end
    end

    // Pick the product for the current band and parity.
    assign prod = cand[band][odd];

endmodule

// File: rtl/poly_decim4.sv
// Polyphase decimate-by-2 four-tap analysis filter.
// Even samples feed taps 1 and 3, odd samples taps 0 and 2. The older pair
// of taps is carried in one partial-sum register. In periodic mode the
// first output is deferred and completed with the line's tail.
// Assumes LINE_LEN is even and at least 2.
module poly_decim4
    import poly_decim4_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int LINE_LEN = 8,
    localparam int PW      = IN_W + COEF_W,
    localparam int OUT_W   = PW + 2,
    localparam int IDX_W   = (LINE_LEN > 2) ? $clog2(LINE_LEN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_valid,
    input  logic                    in_sol,
    input  logic                    hp_sel,
    input  logic                    wrap_en,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_valid
);

    logic [IDX_W-1:0]        idx;
    logic                    is_first, is_odd, is_last;
    band_e                   band_q, band_cur;
    logic                    ext_q, ext_cur;
    logic signed [PW-1:0]    prod_a, prod_b;
    logic signed [PW-1:0]    even_a_q, even_b_q;
    logic signed [OUT_W-1:0] part_q, head_q, odd_sum;
    logic                    wrap_pend_q;

    poly_decim4_seq #(.LINE_LEN(LINE_LEN)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .idx      (idx),
        .is_first (is_first),
        .is_odd   (is_odd),
        .is_last  (is_last)
    );

    // Band and border mode of the line: live at index 0, held afterwards.
    always_comb begin
        band_cur = is_first ? band_e'(hp_sel) : band_q;
        ext_cur  = is_first ? wrap_en : ext_q;
    end

    poly_decim4_pe #(.IN_W(IN_W), .TAP_EVEN(1), .TAP_ODD(0)) pe_near_i (
        .x    (in_data),
        .odd  (is_odd),
        .band (band_cur),
        .prod (prod_a)
    );

    poly_decim4_pe #(.IN_W(IN_W), .TAP_EVEN(3), .TAP_ODD(2)) pe_far_i (
        .x    (in_data),
        .odd  (is_odd),
        .band (band_cur),
        .prod (prod_b)
    );

    // Completed output for an odd sample: newest taps plus carried partial sum.
    assign odd_sum = OUT_W'(prod_a) + OUT_W'(even_a_q) + part_q;

    // Main datapath: hold even products, update the partial sum, emit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q      <= BAND_LO;
            ext_q       <= 1'b0;
            even_a_q    <= '0;
            even_b_q    <= '0;
            part_q      <= '0;
            head_q      <= '0;
            wrap_pend_q <= 1'b0;
            out_data    <= '0;
            out_valid   <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            wrap_pend_q <= 1'b0;
            if (wrap_pend_q) begin
                out_data  <= head_q + part_q;
                out_valid <= 1'b1;
            end
            if (in_valid) begin
                if (is_first) begin
                    band_q <= band_e'(hp_sel);
                    ext_q  <= wrap_en;
                    part_q <= '0;
                end
                if (!is_odd) begin
                    even_a_q <= prod_a;
                    even_b_q <= prod_b;
                end else begin
                    part_q <= OUT_W'(prod_b) + OUT_W'(even_b_q);
                    if (ext_cur && idx == IDX_W'(1)) begin
                        head_q <= odd_sum;
                    end else begin
                        out_data  <= odd_sum;
                        out_valid <= 1'b1;
                    end
                    if (ext_cur && is_last)
                        wrap_pend_q <= 1'b1;
                end
            end
        end
    end

    p_even_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_odd && !wrap_pend_q) |=> !out_valid);

    p_odd_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_odd && !(ext_cur && idx == IDX_W'(1))) |=> out_valid);

    p_deferred_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_odd && ext_cur && idx == IDX_W'(1) && !is_last) |=> !out_valid);

    p_wrap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_last && ext_cur) |=> ##1 out_valid);

    p_start_clears_part_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (part_q == '0));

    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !wrap_pend_q) |=> !out_valid);

endmodule

// File: tb/poly_decim4_tb_top.sv
`timescale 1ns/1ps
module poly_decim4_tb_top;

    localparam int IN_W  = 12;
    localparam int N     = 8;
    localparam int OUT_W = IN_W + 14;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    in_valid = 1'b0;
    logic                    in_sol = 1'b0;
    logic                    hp_sel = 1'b0;
    logic                    wrap_en = 1'b0;
    logic signed [OUT_W-1:0] out_data;
    logic                    out_valid;

    int compared   = 0;
    int mismatched = 0;
    int lx [4][N];

    always #2.5 clk = ~clk;

    poly_decim4 #(.IN_W(IN_W), .LINE_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sol(in_sol), .hp_sel(hp_sel), .wrap_en(wrap_en),
        .out_data(out_data), .out_valid(out_valid)
    );

    function automatic int cf(bit hp, int t);
        int lo [4] = '{-265, 459, 1713, 989};
        int hi [4] = '{-989, 1713, -459, -265};
        return hp ? hi[t] : lo[t];
    endfunction

    // Expected output k of line l; negative indices wrap or count as zero.
    function automatic longint ref_out(int l, int k, bit hp, bit circ);
        longint s = 0;
        for (int t = 0; t < 4; t++) begin
            int j = 2 * k + 1 - t;
            if (j < 0) begin
                if (!circ) continue;
                j += N;
            end
            s += longint'(cf(hp, t)) * longint'(lx[l][j]);
        end
        return s;
    endfunction

    function automatic int pat(int kind, int l, int i);
        case (kind)
            0:       return (i + 1) * 100 - l * 37;
            1:       return (i % 2 == 1) ? 2047 : -2048;
            2:       return (i == (l + 3) % N) ? 1000 : 0;
            default: return ((i * 733 + l * 291) % 4096) - 2048;
        endcase
    endfunction

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_none(input string req);
        chk(req, out_valid == 1'b0, longint'(out_valid), 0);
    endtask

    task automatic expect_val(input string req, input longint e);
        chk({req, " valid"}, out_valid == 1'b1, longint'(out_valid), 1);
        if (out_valid)
            chk({req, " value"}, longint'(out_data) == e, longint'(out_data), e);
    endtask

    // Drive one cycle at a falling edge; return at the next falling edge.
    task automatic push(input bit v, input int d, input bit s, input bit hp, input bit ex);
        in_valid = v;
        in_data  = d[IN_W-1:0];
        in_sol   = s;
        hp_sel   = hp;
        wrap_en  = ex;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
    endtask

    // Stream lines back to back and check every cycle's output.
    task automatic run_lines(input int nlines, input bit hp, input bit ex,
                             input int kind, input bit mark_all, input bit gaps);
        for (int l = 0; l < nlines; l++) begin
            for (int i = 0; i < N; i++) begin
                int  d = pat(kind, l, i);
                bit  s = (i == 0) && (l == 0 || mark_all);
                lx[l][i] = d;
                // Band and mode toggled on non-zero indices must be ignored (R5).
                push(1'b1, d, s, (i == 0) ? hp : !hp, (i == 0) ? ex : !ex);
                if (i % 2 == 0) begin
                    if (i == 0 && l > 0 && ex)
                        expect_val("R9 wrap beside next line start", ref_out(l - 1, 0, hp, 1'b1));
                    else
                        expect_none("R2 even sample silent");
                end else if (ex && i == 1) begin
                    expect_none("R6 first output deferred");
                end else if (i == 1) begin
                    expect_val(hp ? "R5 R4 first output hp" : "R4 first output", ref_out(l, 0, hp, 1'b0));
                end else begin
                    expect_val(mark_all ? "R3 output" : "R10 output", ref_out(l, i / 2, hp, ex));
                end
                if (gaps && i % 2 == 0) begin
                    push(1'b0, 'h5A5, 1'b1, !hp, !ex);
                    expect_none("R7 idle cycle ignored");
                end
            end
        end
        push(1'b0, 0, 1'b0, hp, ex);
        if (ex) expect_val("R6 wrap output", ref_out(nlines - 1, 0, hp, 1'b1));
        else    expect_none("R2 no output after line");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid after reset", out_valid == 1'b0, longint'(out_valid), 0);
        chk("R1 out_data after reset", out_data == '0, longint'(out_data), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_restart();
        for (int i = 0; i < 3; i++)
            push(1'b1, 1500 - i * 900, i == 0, 1'b0, 1'b1);
        run_lines(1, 1'b0, 1'b0, 3, 1'b1, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        run_lines(2, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        run_lines(2, 1'b1, 1'b0, 1, 1'b1, 1'b0);
        run_lines(3, 1'b0, 1'b1, 3, 1'b1, 1'b0);
        run_lines(2, 1'b1, 1'b1, 2, 1'b1, 1'b1);
        t_restart();
        run_lines(2, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        run_lines(3, 1'b1, 1'b1, 1, 1'b1, 1'b0);
        run_lines(2, 1'b0, 1'b1, 0, 1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule